// File: doc/BRIEF.md
# Legacy Shift Unit with Multiply-Quotient Side Register

This block is a single-cycle 32-bit shifter for a processor execute stage. It also owns a 32-bit side register, MQ, and a carry flag. It implements a family of legacy shift operations in three directions: left, right logical and right arithmetic. Each direction comes in up to three flavours:

- a plain or extended flavour that deposits the rotated source into MQ;
- a merge flavour that splices bits of the old MQ into the result under a shift mask;
- a long flavour that uses bit 5 of the shift operand to select an overflow behaviour.

The destination value and the condition field are combinational. They are produced in the same cycle as the operation is presented. MQ and carry are registers. They take their new values on the clock edge of a valid operation. The current MQ and carry are always visible at the outputs.

The shift amount comes from one of two places. It is either the low bits of a register operand or a 5-bit immediate. When the immediate is selected, the overflow bit is treated as zero. Decode, the register file and exception handling sit outside the block.

Top module: `sh_mq_unit`

## Requirements
- R1: The shift amount n is `imm_i` when `imm_sel_i` is 1, and `shamt_i[4:0]` otherwise. The overflow bit is `shamt_i[5]` when `imm_sel_i` is 0, and 0 when `imm_sel_i` is 1.
- R2: Op code 0 gives dst = src << n. Op code 4 gives dst = src >> n (logical). Both load MQ with the source rotated by n: left for code 0, right for code 4.
- R3: Op code 1 gives dst = (rotl(src,n) & M) | (oldMQ & ~M), where M = all-ones << n. Op code 5 gives dst = (rotr(src,n) & M) | (oldMQ & ~M), where M = all-ones >> n. Both load MQ with the same rotate. The merge uses the MQ value from before the operation.
- R4: Op codes 2 (left, M = all-ones << n) and 6 (right, M = all-ones >> n) leave MQ unchanged. With the overflow bit set, dst = oldMQ & M. Otherwise dst = (src shifted by n) | (oldMQ & ~M).
- R5: Op codes 3 (left) and 7 (right) load MQ with the source rotated by n. dst is the logical shift of src by n, forced to zero when the overflow bit is set.
- R6: Op code 8 gives dst = arithmetic right shift of src by n and loads MQ with rotr(src,n).
- R7: Op code 9 loads MQ with rotr(src,n). dst is the arithmetic right shift of src by n, or all copies of src bit 31 when the overflow bit is set.
- R8: Op codes 8 and 9 set carry to 1 only when src bit 31 is 1 and a 1-bit was shifted out. Shifted out means the low n bits, or any bit of src when op code 9 has the overflow bit set. Otherwise these codes clear carry. All other op codes leave carry unchanged.
- R9: `cond_o` is {bit2 = negative, bit1 = positive, bit0 = zero} of `dst_o` taken as signed when `rec_i` is 1. It is 0 when `rec_i` is 0.
- R10: MQ and carry change only on a clock edge where `op_valid_i` is 1. An active-low `rst_n` clears both to zero.
- R11: Op codes 10 to 15 give dst = 0 and leave MQ and carry unchanged.
- R12: With n = 0, every rotate equals the source itself. No result depends on a shift by the full width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| op_valid_i | input | 1 | Operation present this cycle; enables MQ and carry update |
| op_i | input | 4 | Operation code (see requirements) |
| src_i | input | 32 | Source operand |
| shamt_i | input | 6 | Low six bits of the shift register operand |
| imm_i | input | 5 | Immediate shift amount |
| imm_sel_i | input | 1 | 1 selects the immediate amount |
| rec_i | input | 1 | Record flag: produce a condition field |
| dst_o | output | 32 | Destination value (combinational) |
| cond_o | output | 3 | Condition field {neg, pos, zero} |
| mq_o | output | 32 | Current MQ register |
| ca_o | output | 1 | Current carry flag |

## Verification
The assertions have several preconditions on the inputs:
- `op_i`, `src_i`, the amount inputs and `op_valid_i` are known values that stay stable through each rising edge;
- `rst_n` has already been synchronised to `clk`.

The stimulus changes every input only on the falling edge and holds it across the following rising edge. It never drives an unknown value. The sweep covers each op code, both amount sources, every 6-bit shift operand and a set of sources, including negative values with and without low-order ones.

// File: rtl/sh_mq_pkg.sv
package sh_mq_pkg;

  localparam int unsigned OP_W = 4;

  // Operation codes; values 10..15 are reserved and act as no-ops
  typedef enum logic [OP_W-1:0] {
    OP_SHL_EXT     = 4'd0,
    OP_SHL_EXT_MRG = 4'd1,
    OP_SHL_LONG    = 4'd2,
    OP_SHL_MQ      = 4'd3,
    OP_SHR_EXT     = 4'd4,
    OP_SHR_EXT_MRG = 4'd5,
    OP_SHR_LONG    = 4'd6,
    OP_SHR_MQ      = 4'd7,
    OP_SRA_EXT     = 4'd8,
    OP_SRA_MQ      = 4'd9
  } sh_op_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } sh_cond_t;

endpackage

// File: rtl/sh_mq_amount.sv
// Selects the effective shift amount and the overflow (wide) flag.
module sh_mq_amount #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [AW:0]   shamt_i,
  input  logic [AW-1:0] imm_i,
  input  logic          imm_sel_i,
  output logic [AW-1:0] n_o,
  output logic          wide_o
);

  always_comb begin
    if (imm_sel_i) begin
      n_o    = imm_i;
      wide_o = 1'b0;
    end else begin
      n_o    = shamt_i[AW-1:0];
      wide_o = shamt_i[AW];
    end
  end

endmodule

// File: rtl/sh_mq_datapath.sv
// Shift, rotate, mask and merge logic; produces the result and the
// next values for MQ and carry together with their write enables.
module sh_mq_datapath
  import sh_mq_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    src_i,
  input  logic [AW-1:0]   n_i,
  input  logic            wide_i,
  input  logic [W-1:0]    mq_q_i,
  output logic [W-1:0]    dst_o,
  output logic            mq_we_o,
  output logic [W-1:0]    mq_d_o,
  output logic            ca_we_o,
  output logic            ca_d_o
);

  localparam logic [W-1:0] ONES = '1;

  logic [2*W-1:0] dbl;
  logic [2*W-1:0] dbl_l;
  logic [2*W-1:0] dbl_r;
  logic [W-1:0]   rotl;
  logic [W-1:0]   rotr;
  logic [W-1:0]   lmask;
  logic [W-1:0]   rmask;
  logic [W-1:0]   shl;
  logic [W-1:0]   shr;
  logic [W-1:0]   sra;
  logic           neg;
  logic           lost;

  // Funnel through a doubled operand: a rotate by 0 is the source itself
  // and no width-W shift of the operand is ever needed.
  always_comb begin
    dbl   = {src_i, src_i};
    dbl_l = dbl << n_i;
    dbl_r = dbl >> n_i;
    rotl  = dbl_l[2*W-1:W];
    rotr  = dbl_r[W-1:0];
    lmask = ONES << n_i;
    rmask = ONES >> n_i;
    shl   = src_i << n_i;
    shr   = src_i >> n_i;
    neg   = src_i[W-1];
    sra   = shr | (neg ? ~rmask : '0);
    lost  = |(src_i & ~lmask);
  end

  always_comb begin
    dst_o   = '0;
    mq_we_o = 1'b0;
    mq_d_o  = mq_q_i;
    ca_we_o = 1'b0;
    ca_d_o  = 1'b0;
    case (op_i)
      OP_SHL_EXT: begin
        dst_o   = shl;
        mq_we_o = 1'b1;
        mq_d_o  = rotl;
      end
      OP_SHL_EXT_MRG: begin
        dst_o   = (rotl & lmask) | (mq_q_i & ~lmask);
        mq_we_o = 1'b1;
        mq_d_o  = rotl;
      end
      OP_SHL_LONG: begin
        dst_o = wide_i ? (mq_q_i & lmask) : (shl | (mq_q_i & ~lmask));
      end
      OP_SHL_MQ: begin
        dst_o   = wide_i ? '0 : shl;
        mq_we_o = 1'b1;
        mq_d_o  = rotl;
      end
      OP_SHR_EXT: begin
        dst_o   = shr;
        mq_we_o = 1'b1;
        mq_d_o  = rotr;
      end
      OP_SHR_EXT_MRG: begin
        dst_o   = (rotr & rmask) | (mq_q_i & ~rmask);
        mq_we_o = 1'b1;
        mq_d_o  = rotr;
      end
      OP_SHR_LONG: begin
        dst_o = wide_i ? (mq_q_i & rmask) : (shr | (mq_q_i & ~rmask));
      end
      OP_SHR_MQ: begin
        dst_o   = wide_i ? '0 : shr;
        mq_we_o = 1'b1;
        mq_d_o  = rotr;
      end
      OP_SRA_EXT: begin
        dst_o   = sra;
        mq_we_o = 1'b1;
        mq_d_o  = rotr;
        ca_we_o = 1'b1;
        ca_d_o  = neg & lost;
      end
      OP_SRA_MQ: begin
        dst_o   = wide_i ? {W{neg}} : sra;
        mq_we_o = 1'b1;
        mq_d_o  = rotr;
        ca_we_o = 1'b1;
        ca_d_o  = wide_i ? neg : (neg & lost);
      end
      default: begin
        dst_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/sh_mq_cond.sv
// Signed condition field of the final result, gated by the record flag.
module sh_mq_cond
  import sh_mq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] dst_i,
  input  logic         rec_i,
  output sh_cond_t     cond_o
);

  logic is_zero;

  always_comb begin
    is_zero = (dst_i == '0);
    cond_o  = '0;
    if (rec_i) begin
      cond_o.lt = dst_i[W-1];
      cond_o.eq = is_zero;
      cond_o.gt = ~dst_i[W-1] & ~is_zero;
    end
  end

endmodule

// File: rtl/sh_mq_state.sv
// MQ register and carry flag with explicit write enables.
module sh_mq_state #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic         mq_we_i,
  input  logic [W-1:0] mq_d_i,
  input  logic         ca_we_i,
  input  logic         ca_d_i,
  output logic [W-1:0] mq_q_o,
  output logic         ca_q_o
);

  logic         mq_en;
  logic         ca_en;
  logic [W-1:0] mq_n;
  logic         ca_n;

  always_comb begin
    mq_en = valid_i & mq_we_i;
    ca_en = valid_i & ca_we_i;
    mq_n  = mq_en ? mq_d_i : mq_q_o;
    ca_n  = ca_en ? ca_d_i : ca_q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq_q_o <= '0;
      ca_q_o <= 1'b0;
    end else begin
      mq_q_o <= mq_n;
      ca_q_o <= ca_n;
    end
  end

endmodule

// File: rtl/sh_mq_unit.sv
module sh_mq_unit
  import sh_mq_pkg::*;
#(
  parameter  int unsigned W  = 32,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    src_i,
  input  logic [AW:0]     shamt_i,
  input  logic [AW-1:0]   imm_i,
  input  logic            imm_sel_i,
  input  logic            rec_i,
  output logic [W-1:0]    dst_o,
  output logic [2:0]      cond_o,
  output logic [W-1:0]    mq_o,
  output logic            ca_o
);

  logic [AW-1:0] n;
  logic          wide;
  logic          mq_we;
  logic [W-1:0]  mq_d;
  logic          ca_we;
  logic          ca_d;
  sh_cond_t      cond;

  sh_mq_amount #(.W(W), .AW(AW)) u_amount (
    .shamt_i   (shamt_i),
    .imm_i     (imm_i),
    .imm_sel_i (imm_sel_i),
    .n_o       (n),
    .wide_o    (wide)
  );

  sh_mq_datapath #(.W(W), .AW(AW)) u_dp (
    .op_i    (op_i),
    .src_i   (src_i),
    .n_i     (n),
    .wide_i  (wide),
    .mq_q_i  (mq_o),
    .dst_o   (dst_o),
    .mq_we_o (mq_we),
    .mq_d_o  (mq_d),
    .ca_we_o (ca_we),
    .ca_d_o  (ca_d)
  );

  sh_mq_cond #(.W(W)) u_cond (
    .dst_i  (dst_o),
    .rec_i  (rec_i),
    .cond_o (cond)
  );

  sh_mq_state #(.W(W)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (op_valid_i),
    .mq_we_i (mq_we),
    .mq_d_i  (mq_d),
    .ca_we_i (ca_we),
    .ca_d_i  (ca_d),
    .mq_q_o  (mq_o),
    .ca_q_o  (ca_o)
  );

  assign cond_o = cond;

endmodule

// File: rtl/sh_mq_unit_chk.sv
module sh_mq_unit_chk #(
  parameter  int unsigned W  = 32,
  localparam int unsigned AW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid_i,
  input logic [3:0]    op_i,
  input logic [W-1:0]  src_i,
  input logic [AW:0]   shamt_i,
  input logic [AW-1:0] imm_i,
  input logic          imm_sel_i,
  input logic          rec_i,
  input logic [W-1:0]  dst_o,
  input logic [2:0]    cond_o,
  input logic [W-1:0]  mq_o,
  input logic          ca_o
);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> ($stable(mq_o) && $stable(ca_o)));

  assert_long_keeps_mq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && (op_i == 4'd2 || op_i == 4'd6)) |=> $stable(mq_o));

  assert_carry_only_algebraic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_i != 4'd8 && op_i != 4'd9) |=> $stable(ca_o));

  assert_carry_needs_negative_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && (op_i == 4'd8 || op_i == 4'd9) && !src_i[W-1]) |=> !ca_o);

  assert_zero_rotate_is_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && (op_i == 4'd0 || op_i == 4'd4) && imm_sel_i && imm_i == '0)
      |=> (mq_o == $past(src_i)));

  assert_unused_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_i > 4'd9) |-> (dst_o == '0) ##1 ($stable(mq_o) && $stable(ca_o)));

  assert_cond_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cond_o));

  assert_cond_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_i |-> (cond_o == 3'b000));

  assert_cond_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_i && dst_o == '0) |-> (cond_o == 3'b001));

endmodule

bind sh_mq_unit sh_mq_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid_i (op_valid_i),
  .op_i       (op_i),
  .src_i      (src_i),
  .shamt_i    (shamt_i),
  .imm_i      (imm_i),
  .imm_sel_i  (imm_sel_i),
  .rec_i      (rec_i),
  .dst_o      (dst_o),
  .cond_o     (cond_o),
  .mq_o       (mq_o),
  .ca_o       (ca_o)
);

// File: tb/tb_sh_mq_unit.sv
module tb_sh_mq_unit;

  logic        clk;
  logic        rst_n;
  logic        op_valid_i;
  logic [3:0]  op_i;
  logic [31:0] src_i;
  logic [5:0]  shamt_i;
  logic [4:0]  imm_i;
  logic        imm_sel_i;
  logic        rec_i;
  logic [31:0] dst_o;
  logic [2:0]  cond_o;
  logic [31:0] mq_o;
  logic        ca_o;

  int checks;
  int errors;

  logic [31:0] m_mq;
  logic        m_ca;

  sh_mq_unit dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid_i (op_valid_i),
    .op_i       (op_i),
    .src_i      (src_i),
    .shamt_i    (shamt_i),
    .imm_i      (imm_i),
    .imm_sel_i  (imm_sel_i),
    .rec_i      (rec_i),
    .dst_o      (dst_o),
    .cond_o     (cond_o),
    .mq_o       (mq_o),
    .ca_o       (ca_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd4: return "R2";
      4'd1, 4'd5: return "R3";
      4'd2, 4'd6: return "R4";
      4'd3, 4'd7: return "R5";
      4'd8:       return "R6";
      4'd9:       return "R7";
      default:    return "R11";
    endcase
  endfunction

  // Arithmetic reference model built from the requirement text
  task automatic model(input logic [3:0] op, input logic [31:0] s, input logic [4:0] n,
                       input logic wide, output logic [31:0] dst,
                       output logic [31:0] mq_n, output logic ca_n);
    logic [63:0] s64;
    logic [31:0] rl, rr, lm, rm, sl, sr, sa;
    logic        drop;
    s64  = {32'h0, s};
    rl   = 32'((s64 << n) | (s64 >> (32 - int'(n))));
    rr   = 32'((s64 >> n) | (s64 << (32 - int'(n))));
    lm   = 32'hFFFF_FFFF << n;
    rm   = 32'hFFFF_FFFF >> n;
    sl   = s << n;
    sr   = s >> n;
    sa   = sr | (s[31] ? ~rm : 32'h0);
    drop = (((s >> n) << n) != s);
    dst  = 32'h0;
    mq_n = m_mq;
    ca_n = m_ca;
    case (op)
      4'd0: begin dst = sl; mq_n = rl; end
      4'd1: begin dst = (rl & lm) | (m_mq & ~lm); mq_n = rl; end
      4'd2: dst = wide ? (m_mq & lm) : (sl | (m_mq & ~lm));
      4'd3: begin dst = wide ? 32'h0 : sl; mq_n = rl; end
      4'd4: begin dst = sr; mq_n = rr; end
      4'd5: begin dst = (rr & rm) | (m_mq & ~rm); mq_n = rr; end
      4'd6: dst = wide ? (m_mq & rm) : (sr | (m_mq & ~rm));
      4'd7: begin dst = wide ? 32'h0 : sr; mq_n = rr; end
      4'd8: begin dst = sa; mq_n = rr; ca_n = s[31] & drop; end
      4'd9: begin
        dst  = wide ? {32{s[31]}} : sa;
        mq_n = rr;
        ca_n = wide ? s[31] : (s[31] & drop);
      end
      default: dst = 32'h0;
    endcase
  endtask

  function automatic logic [31:0] pattern(input int i);
    case (i)
      0: return 32'h8000_0000;
      1: return 32'hC3A5_0F17;
      2: return 32'h5A5A_1234;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [31:0] s, input logic [5:0] amt,
                        input logic isel, input logic rec);
    logic [4:0]  n;
    logic        wide;
    logic [31:0] e_dst, e_mq;
    logic        e_ca;
    logic [2:0]  e_cond;
    string       tag;
    @(negedge clk);
    op_valid_i = 1'b1;
    op_i       = op;
    src_i      = s;
    imm_sel_i  = isel;
    rec_i      = rec;
    if (isel) begin
      imm_i   = amt[4:0];
      shamt_i = ~amt;
    end else begin
      shamt_i = amt;
      imm_i   = ~amt[4:0];
    end
    n    = amt[4:0];
    wide = isel ? 1'b0 : amt[5];
    model(op, s, n, wide, e_dst, e_mq, e_ca);
    tag = {req_of(op), " R1"};
    if (n == 5'd0) tag = {tag, " R12"};
    #1;
    check(tag, dst_o, e_dst);
    e_cond = rec ? {e_dst[31], (!e_dst[31] && e_dst != 0), (e_dst == 0)} : 3'b000;
    check("R9 cond", {29'h0, cond_o}, {29'h0, e_cond});
    @(posedge clk);
    #1;
    check({tag, " mq"}, mq_o, e_mq);
    check("R8 carry", {31'h0, ca_o}, {31'h0, e_ca});
    m_mq = e_mq;
    m_ca = e_ca;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    op_valid_i = 1'b0;
    op_i       = 4'd0;
    src_i      = 32'h1234_5679;
    shamt_i    = 6'd3;
    imm_sel_i  = 1'b0;
    @(posedge clk);
    #1;
    check("R10 idle mq", mq_o, m_mq);
    check("R10 idle carry", {31'h0, ca_o}, {31'h0, m_ca});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks     = 0;
    errors     = 0;
    rst_n      = 1'b0;
    op_valid_i = 1'b0;
    op_i       = 4'd0;
    src_i      = 32'h0;
    shamt_i    = 6'd0;
    imm_i      = 5'd0;
    imm_sel_i  = 1'b0;
    rec_i      = 1'b0;
    m_mq       = 32'h0;
    m_ca       = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    check("R10 reset mq", mq_o, 32'h0);
    check("R10 reset carry", {31'h0, ca_o}, 32'h0);

    for (int p = 0; p < 4; p++) begin
      for (int op = 0; op < 16; op++) begin
        for (int isel = 0; isel < 2; isel++) begin
          for (int a = 0; a < 64; a++) begin
            run_op(4'(op), pattern(p) ^ (32'(a) << 8), 6'(a), isel[0], a[0] ^ p[0]);
            if (a == 17) idle_cycle();
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule